// File: doc/BRIEF.md
# Parameterised Control/Status Register Bank

This block holds a set of 16-bit control and status registers behind a simple processor-side bus. A combinational decoder turns a synchronised register address and an active-low chip select into a one-hot select vector with one line per register. Every register is built bit by bit. A used bit is a flip-flop that loads its own default value on reset. An unused bit has no storage at all and is tied to its default value.

Both the processor and the core can write to the bank in the same way: a write strobe plus a data word, applied to the register that is currently selected. The processor wins if both sides write in the same cycle. A read request returns the selected register on a 16-bit readback bus one clock later, together with a single-cycle ready strobe. The current contents of every register also leave the block on a flat bus for the core to use.

Top module: `csr_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads every register with its default from `RST_VAL`, where register i occupies bits [16*i+15:16*i] of the flat bus. After the same edge `rd_ready` is low and `rd_data` is zero.
- R2: Reset takes priority over any write presented in the same cycle.
- R3: A used bit (`USED_MASK` bit set) captures the matching write-data bit at the clock edge where its register is selected and a write strobe is high. Otherwise it keeps its value.
- R4: An unused bit (`USED_MASK` bit clear) always reads as its `RST_VAL` bit, whatever is written to it.
- R5: When `cpu_wr` and `core_wr` are both high, `cpu_wdata` is written. When only `core_wr` is high, `core_wdata` is written.
- R6: Address value i, for i below `NUM_REGS`, selects register i and no other. A write changes only that register.
- R7: While `csb_sync` is high, nothing is selected. No register changes, and a read gives `rd_ready` low and `rd_data` zero.
- R8: An address of `NUM_REGS` or above selects nothing. Writes there have no effect, and a read gives `rd_ready` low and `rd_data` zero.
- R9: A valid read (`rd_req` high, `csb_sync` low, valid address) puts the register's value from before the edge on `rd_data` at the next edge. `rd_ready` is high for that one cycle and low again after the next edge if `rd_req` has dropped.
- R10: The readback multiplexer outputs zero for any select pattern that is not one-hot. The address width is the base-2 logarithm of `NUM_REGS`, rounded up, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous reset, active high |
| csb_sync | input | 1 | Synchronised chip select, active low |
| addr_sync | input | ADDR_W | Synchronised register index |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 16 | Processor write data |
| core_wr | input | 1 | Core write strobe |
| core_wdata | input | 16 | Core write data |
| rd_req | input | 1 | Read request |
| rd_data | output | 16 | Registered readback word |
| rd_ready | output | 1 | Readback valid strobe |
| reg_q | output | 16*NUM_REGS | Current contents of all registers |

## Verification
A wrong bit of register state appears on `reg_q` right after the edge that stored it, and on `rd_data` one edge after a read of that register. A decoder that selects the wrong line, or more than one line, shows up as a change in a register that was not addressed on the same edge. A wrong strobe shows up as `rd_ready` high one cycle after an invalid or deselected read. A stray flip-flop on an unused bit shows up as soon as a write puts a value on it that differs from its default.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
    localparam int WORD_W = 16;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t rd_data;
        logic  rd_ready;
    } rd_state_t;
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec #(
    parameter int NUM_REGS = 5,
    parameter int ADDR_W   = 3
) (
    input  logic              rst,
    input  logic              csb_sync,
    input  logic [ADDR_W-1:0] addr_sync,
    output logic [NUM_REGS-1:0] sel
);
    logic enable;
    assign enable = !rst && !csb_sync;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_line
        assign sel[i] = enable && (addr_sync == ADDR_W'(i));
    end
endmodule

// File: rtl/csr_reg.sv
module csr_reg
    import csr_bank_pkg::*;
#(
    parameter word_t DEFAULT_VAL = '0,
    parameter word_t USED_BITS   = '1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_data,
    output word_t q
);
    // Tie-off for inputs that a fully hard-wired register never reads.
    logic unused_inputs;
    assign unused_inputs = ^{wr_data & ~USED_BITS, clk, rst, wr_en};

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (USED_BITS[b]) begin : g_used
            logic bit_d, bit_q;

            always_comb begin
                bit_d = bit_q;
                if (rst)
                    bit_d = DEFAULT_VAL[b];
                else if (wr_en)
                    bit_d = wr_data[b];
            end

            always_ff @(posedge clk) begin
                bit_q <= bit_d;
            end

            assign q[b] = bit_q;
        end else begin : g_fixed
            assign q[b] = DEFAULT_VAL[b];
        end
    end
endmodule

// File: rtl/csr_rd_mux.sv
module csr_rd_mux
    import csr_bank_pkg::*;
#(
    parameter int NUM_REGS = 5
) (
    input  logic [NUM_REGS-1:0]        sel,
    input  logic [NUM_REGS*WORD_W-1:0] regs,
    output word_t                      dout
);
    always_comb begin
        dout = '0;
        if ($countones(sel) == 1) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (sel[i])
                    dout = regs[i*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_bank_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter logic [NUM_REGS*16-1:0] RST_VAL =
        {16'h5A5A, 16'hA5C3, 16'h00FF, 16'h1234, 16'hBEEF},
    parameter logic [NUM_REGS*16-1:0] USED_MASK =
        {16'h0000, 16'h0FF0, 16'hFFFF, 16'h00FF, 16'hF0F0},
    localparam int ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   csb_sync,
    input  logic [ADDR_W-1:0]      addr_sync,
    input  logic                   cpu_wr,
    input  logic [15:0]            cpu_wdata,
    input  logic                   core_wr,
    input  logic [15:0]            core_wdata,
    input  logic                   rd_req,
    output logic [15:0]            rd_data,
    output logic                   rd_ready,
    output logic [NUM_REGS*16-1:0] reg_q
);
    logic [NUM_REGS-1:0] sel;
    logic                wr_any;
    word_t               wr_word;
    word_t               mux_out;
    rd_state_t           state_d, state_q;

    csr_addr_dec #(
        .NUM_REGS(NUM_REGS),
        .ADDR_W  (ADDR_W)
    ) u_dec (
        .rst      (rst),
        .csb_sync (csb_sync),
        .addr_sync(addr_sync),
        .sel      (sel)
    );

    // Processor side wins when both sides write together.
    assign wr_any  = cpu_wr || core_wr;
    assign wr_word = cpu_wr ? cpu_wdata : core_wdata;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        csr_reg #(
            .DEFAULT_VAL(RST_VAL[i*WORD_W +: WORD_W]),
            .USED_BITS  (USED_MASK[i*WORD_W +: WORD_W])
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (sel[i] && wr_any),
            .wr_data(wr_word),
            .q      (reg_q[i*WORD_W +: WORD_W])
        );
    end

    csr_rd_mux #(
        .NUM_REGS(NUM_REGS)
    ) u_mux (
        .sel (sel),
        .regs(reg_q),
        .dout(mux_out)
    );

    always_comb begin
        state_d          = '0;
        state_d.rd_ready = rd_req && (|sel);
        if (rd_req && !rst)
            state_d.rd_data = mux_out;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign rd_data  = state_q.rd_data;
    assign rd_ready = state_q.rd_ready;
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
    parameter int NUM_REGS = 5,
    parameter int ADDR_W   = 3,
    parameter logic [NUM_REGS*16-1:0] RST_VAL = '0
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   csb_sync,
    input logic [ADDR_W-1:0]      addr_sync,
    input logic                   cpu_wr,
    input logic                   core_wr,
    input logic                   rd_req,
    input logic [NUM_REGS-1:0]    sel,
    input logic                   rd_ready,
    input logic [NUM_REGS*16-1:0] reg_q
);
    // R1
    rst_load_chk: assert property (@(posedge clk)
        rst |=> (reg_q == RST_VAL));

    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R7
    csb_idle_chk: assert property (@(posedge clk) disable iff (rst)
        csb_sync |-> (sel == '0));

    // R8
    bad_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (csb_sync || int'(addr_sync) >= NUM_REGS)) |=> !rd_ready);

    // R9
    good_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !csb_sync && int'(addr_sync) < NUM_REGS) |=> rd_ready);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_wr || core_wr) |=> $stable(reg_q));
endmodule

bind csr_bank csr_bank_chk #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W),
    .RST_VAL (RST_VAL)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .csb_sync (csb_sync),
    .addr_sync(addr_sync),
    .cpu_wr   (cpu_wr),
    .core_wr  (core_wr),
    .rd_req   (rd_req),
    .sel      (sel),
    .rd_ready (rd_ready),
    .reg_q    (reg_q)
);

// File: tb/sim_csr_bank.sv
module sim_csr_bank;
    localparam int N = 5;
    localparam int AW = 3;
    localparam logic [N*16-1:0] DEFS =
        {16'h5A5A, 16'hA5C3, 16'h00FF, 16'h1234, 16'hBEEF};
    localparam logic [N*16-1:0] MASK =
        {16'h0000, 16'h0FF0, 16'hFFFF, 16'h00FF, 16'hF0F0};

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            csb_sync = 1'b1;
    logic [AW-1:0]   addr_sync = '0;
    logic            cpu_wr = 1'b0;
    logic [15:0]     cpu_wdata = '0;
    logic            core_wr = 1'b0;
    logic [15:0]     core_wdata = '0;
    logic            rd_req = 1'b0;
    logic [15:0]     rd_data;
    logic            rd_ready;
    logic [N*16-1:0] reg_q;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] model [N];

    always #2 clk = ~clk;

    csr_bank #(.NUM_REGS(N), .RST_VAL(DEFS), .USED_MASK(MASK)) u0 (
        .clk(clk), .rst(rst), .csb_sync(csb_sync), .addr_sync(addr_sync),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .core_wr(core_wr),
        .core_wdata(core_wdata), .rd_req(rd_req), .rd_data(rd_data),
        .rd_ready(rd_ready), .reg_q(reg_q)
    );

    function automatic logic [15:0] merged(int i, logic [15:0] w);
        return (w & MASK[i*16 +: 16]) | (DEFS[i*16 +: 16] & ~MASK[i*16 +: 16]);
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < N; i++)
            check(req, reg_q[i*16 +: 16], model[i]);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_wr = 0; core_wr = 0; rd_req = 0; csb_sync = 1;
    endtask

    task automatic write(bit cpu, bit core, int a, logic [15:0] cd,
                         logic [15:0] kd, bit csb);
        csb_sync = csb; addr_sync = AW'(a);
        cpu_wr = cpu; cpu_wdata = cd; core_wr = core; core_wdata = kd;
        step();
        idle();
    endtask

    task automatic read(int a, bit csb, string req,
                        logic [15:0] exp_d, logic exp_r);
        csb_sync = csb; addr_sync = AW'(a); rd_req = 1;
        step();
        idle();
        check(req, rd_data, exp_d);
        check(req, 16'(rd_ready), 16'(exp_r));
        step();
        check({req, " ready drop"}, 16'(rd_ready), 16'h0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) model[i] = DEFS[i*16 +: 16];
        rst = 1; step(); step();
        check_all("R1 reset value");
        check("R1 rd_ready", 16'(rd_ready), 16'h0);
        check("R1 rd_data", rd_data, 16'h0);
        rst = 0; step();
    endtask

    task automatic t_writes();
        for (int i = 0; i < N; i++) begin
            logic [15:0] w = 16'h3C96 ^ 16'(i * 16'h1111);
            write(1, 0, i, w, 16'h0, 0);
            model[i] = merged(i, w);
            check_all("R3 R4 R6 cpu write");
        end
        write(0, 1, 2, 16'h0, 16'hC0DE, 0);
        model[2] = merged(2, 16'hC0DE);
        check_all("R5 core write");
        write(0, 1, 1, 16'h0, 16'hFFFF, 0);
        model[1] = merged(1, 16'hFFFF);
        check_all("R4 unused bits keep default");
        write(0, 1, 4, 16'h0, 16'h0000, 0);
        check_all("R4 fully fixed register");
    endtask

    task automatic t_priority();
        write(1, 1, 2, 16'h1357, 16'h2468, 0);
        model[2] = merged(2, 16'h1357);
        check_all("R5 cpu over core");
    endtask

    task automatic t_deselect();
        write(1, 0, 2, 16'hDEAD, 16'h0, 1);
        check_all("R7 csb write ignored");
        read(2, 1, "R7 csb read", 16'h0, 0);
        for (int a = N; a < (1 << AW); a++) begin
            write(1, 1, a, 16'hFFFF, 16'hFFFF, 0);
            check_all("R8 bad address write ignored");
            read(a, 0, "R8 bad address read", 16'h0, 0);
        end
    endtask

    task automatic t_reads();
        for (int i = 0; i < N; i++)
            read(i, 0, "R9 R10 readback", model[i], 1);
        // read and write in the same cycle returns the old contents
        csb_sync = 0; addr_sync = 3'd0; rd_req = 1;
        cpu_wr = 1; cpu_wdata = 16'h0F0F;
        step();
        idle();
        check("R9 old value on concurrent write", rd_data, model[0]);
        model[0] = merged(0, 16'h0F0F);
        check_all("R9 concurrent write lands");
    endtask

    task automatic t_reset_priority();
        rst = 1;
        write(1, 0, 2, 16'h4321, 16'h0, 0);
        rst = 0;
        for (int i = 0; i < N; i++) model[i] = DEFS[i*16 +: 16];
        check_all("R2 reset over write");
    endtask

    initial begin
        #(4 * 20000);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_writes();
        t_priority();
        t_deselect();
        t_reads();
        t_reset_priority();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule